// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block sits beside a processor core on an always-running clock. It decides when the core clock may stop and when it may start again. When the core asks to sleep and standby is enabled, the block stops the core clock and shows "standby" on a two-bit status output. It also captures a watchdog start value and a clock-divider select from configuration inputs. When standby is disabled, a sleep request leads only to a light sleep in which the core clock keeps running.

Wake sources are a non-maskable interrupt (NMI), an encoded 4-bit interrupt level, a 4-bit GPIO wake level and a flag that reports whether the real-time-clock oscillator runs. These inputs arrive while the core clock is stopped, so each passes through two flip-flops before it is used. A qualified wake in standby starts an up-counter from the captured start value. The core clock is released only when that counter overflows, which gives the oscillator time to settle. On the cycle the core resumes, a one-cycle wake pulse is raised together with a code that names the source. An asynchronous reset ends standby at once, with no settling count.

Top module: `stby_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are `core_clk_en`=1, `status1`=1, `status0`=1, `wake_pulse`=0, `wake_code`=0 and `div_sel`=0, even when reset arrives in standby. After release, no wake pulse follows from a standby that reset cut short.
- R2: In the running state, `sleep_req` with `stby_en`=1 gives `core_clk_en`=0, `status1`=0 and `status0`=1 after the next clock edge. The same edge loads `cfg_wdt_start` into the watchdog and `cfg_div_sel` into `div_sel`.
- R3: In standby, a qualified wake reaches the settling counter two synchronizer edges after it is sampled, and the counter starts at the loaded value. `wake_pulse` appears at edge number 4 + (2^WDT_W − 1 − start), counting the first edge that samples the input as edge 1. Until then `core_clk_en` stays 0 and the status stays at standby.
- R4: On a wake, `wake_pulse` is high for exactly one cycle. In that same cycle `core_clk_en`=1 and `status1`=`status0`=0.
- R5: `wake_code` is 3'd1 for NMI, 3'd2 for the encoded interrupt and 3'd3 for GPIO. When several sources are valid in the same cycle, NMI wins over the encoded interrupt, which wins over GPIO.
- R6: The encoded interrupt and GPIO wake the block only when their level is strictly greater than `imask`. A level equal to the mask does not wake it.
- R7: The encoded interrupt and GPIO wake the block only while `rtc_run`=1. NMI wakes the block whatever the value of `rtc_run`.
- R8: In standby, `int_block` has no effect. In light sleep, `int_block`=1 suppresses encoded-interrupt and GPIO wakes but not NMI.
- R9: `sleep_req` with `stby_en`=0 enters light sleep. There `core_clk_en` stays 1 and the status stays 00. A qualified wake gives `wake_pulse` at edge 3 (two synchronizer edges plus one), with no watchdog count.
- R10: In the running state, wake inputs never produce `wake_pulse`.
- R11: `div_sel` changes only on entry to standby. A change of `cfg_div_sel` at any other time is not visible at `div_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request from the core |
| stby_en | input | 1 | 1 selects standby, 0 selects light sleep |
| cfg_wdt_start | input | WDT_W | Watchdog start value |
| cfg_div_sel | input | DIV_W | Clock divider select to capture |
| imask | input | LVL_W | Interrupt mask level |
| int_block | input | 1 | Global interrupt block flag |
| nmi | input | 1 | Non-maskable interrupt |
| irl_lvl | input | LVL_W | Encoded interrupt level, 0 means none |
| gpio_lvl | input | LVL_W | GPIO wake level |
| rtc_run | input | 1 | Real-time-clock oscillator running |
| core_clk_en | output | 1 | Core clock enable |
| status1 | output | 1 | Status bit 1 |
| status0 | output | 1 | Status bit 0 |
| div_sel | output | DIV_W | Captured divider select |
| wake_pulse | output | 1 | One-cycle wake exception request |
| wake_code | output | 3 | Source of the last wake |

## Verification
Standby wakes are tried with NMI, the encoded interrupt and GPIO on their own, so each code is seen. Each source is also tried with levels just above and exactly at the mask, which shows that the compare is strict. The same sources are tried with the real-time clock stopped, which separates the NMI path from the gated paths, and with sources arriving together, which checks the priority order. Several watchdog start values, from near overflow down to zero, show the settling length. Light sleep is tried with the block flag both set and clear, which tells the two sleep modes apart.

// File: rtl/stby_ctrl.sv
`timescale 1ns/1ps
module stby_ctrl #(
  parameter int WDT_W = 8,
  parameter int DIV_W = 2,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             stby_en,
  input  logic [WDT_W-1:0] cfg_wdt_start,
  input  logic [DIV_W-1:0] cfg_div_sel,
  input  logic [LVL_W-1:0] imask,
  input  logic             int_block,
  input  logic             nmi,
  input  logic [LVL_W-1:0] irl_lvl,
  input  logic [LVL_W-1:0] gpio_lvl,
  input  logic             rtc_run,
  output logic             core_clk_en,
  output logic             status1,
  output logic             status0,
  output logic [DIV_W-1:0] div_sel,
  output logic             wake_pulse,
  output logic [2:0]       wake_code
);
  localparam int SW = 2 + 2 * LVL_W;
  localparam logic [1:0] S_RUN = 2'd0, S_SLP = 2'd1, S_STB = 2'd2, S_SET = 2'd3;
  localparam logic [2:0] C_NONE = 3'd0, C_NMI = 3'd1, C_IRL = 3'd2, C_GPIO = 3'd3;

  logic [1:0]       st;
  logic [WDT_W-1:0] cnt;
  logic [2:0]       pend;
  logic [SW-1:0]    sy1, sy2;

  logic             nmi_s, rtc_s, mask_ok, irl_hit, gpio_hit, stopped;
  logic [LVL_W-1:0] irl_s, gpio_s;
  logic [2:0]       src;

  assign {nmi_s, rtc_s, irl_s, gpio_s} = sy2;
  assign mask_ok  = (st == S_SLP) ? !int_block : 1'b1;
  assign irl_hit  = rtc_s && (irl_s > imask) && mask_ok;
  assign gpio_hit = rtc_s && (gpio_s > imask) && mask_ok;
  assign src      = nmi_s ? C_NMI : irl_hit ? C_IRL : gpio_hit ? C_GPIO : C_NONE;

  assign stopped     = (st == S_STB) || (st == S_SET);
  assign core_clk_en = !stopped;
  assign status1     = !rst_n;
  assign status0     = !rst_n || stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      cnt        <= '0;
      pend       <= C_NONE;
      div_sel    <= '0;
      wake_pulse <= 1'b0;
      wake_code  <= C_NONE;
      sy1        <= '0;
      sy2        <= '0;
    end else begin
      sy1        <= {nmi, rtc_run, irl_lvl, gpio_lvl};
      sy2        <= sy1;
      wake_pulse <= 1'b0;
      case (st)
        S_RUN: if (sleep_req) begin
          if (stby_en) begin
            st      <= S_STB;
            cnt     <= cfg_wdt_start;
            div_sel <= cfg_div_sel;
          end else begin
            st <= S_SLP;
          end
        end
        S_SLP: if (src != C_NONE) begin
          st         <= S_RUN;
          wake_pulse <= 1'b1;
          wake_code  <= src;
        end
        S_STB: if (src != C_NONE) begin
          st   <= S_SET;
          pend <= src;
        end
        default: if (&cnt) begin
          st         <= S_RUN;
          wake_pulse <= 1'b1;
          wake_code  <= pend;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/stby_ctrl_chk.sv
`timescale 1ns/1ps
module stby_ctrl_chk #(
  parameter int WDT_W = 8,
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic             stby_en,
  input logic [1:0]       st,
  input logic [WDT_W-1:0] cnt,
  input logic             core_clk_en,
  input logic             status1,
  input logic             status0,
  input logic [DIV_W-1:0] div_sel,
  input logic             wake_pulse,
  input logic [2:0]       wake_code
);
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && sleep_req && stby_en) |=> (!core_clk_en && status0 && !status1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !(&cnt)) |=> (st == 2'd3 && !core_clk_en));
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> wake_pulse);
  a_r4_exit: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (core_clk_en && !status0 && !status1));
  a_r4_once: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  a_r5_code: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (wake_code != 3'd0 && wake_code <= 3'd3));
  a_r9_light: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (core_clk_en && !status0));
  a_r10_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |=> !wake_pulse);
  a_r11_div: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0 || !sleep_req || !stby_en) |=> $stable(div_sel));
endmodule

bind stby_ctrl stby_ctrl_chk #(.WDT_W(WDT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_en(stby_en),
  .st(st), .cnt(cnt), .core_clk_en(core_clk_en), .status1(status1),
  .status0(status0), .div_sel(div_sel), .wake_pulse(wake_pulse),
  .wake_code(wake_code)
);

// File: tb/sim_stby_ctrl.sv
`timescale 1ns/1ps
module sim_stby_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0, stby_en = 1'b0;
  logic [7:0] cfg_wdt_start = '0;
  logic [1:0] cfg_div_sel = '0;
  logic [3:0] imask = '0, irl_lvl = '0, gpio_lvl = '0;
  logic int_block = 1'b0, nmi = 1'b0, rtc_run = 1'b0;
  logic core_clk_en, status1, status0, wake_pulse;
  logic [1:0] div_sel;
  logic [2:0] wake_code;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  stby_ctrl u0 (.*);

  // {stby, blk, rtc, nmi, irl[4], gpio[4], imask[4], start[8], code[3]}
  localparam logic [26:0] VEC [0:13] = '{
    {1'b1,1'b0,1'b1,1'b1,4'd0,4'd0,4'd0,8'd250,3'd1},  // R5 nmi
    {1'b1,1'b0,1'b1,1'b0,4'd5,4'd0,4'd4,8'd252,3'd2},  // R6 above mask
    {1'b1,1'b0,1'b1,1'b0,4'd4,4'd0,4'd4,8'd250,3'd0},  // R6 equal mask
    {1'b1,1'b0,1'b1,1'b0,4'd0,4'd7,4'd2,8'd200,3'd3},  // R5 gpio
    {1'b1,1'b0,1'b0,1'b0,4'd9,4'd9,4'd0,8'd250,3'd0},  // R7 rtc stopped
    {1'b1,1'b0,1'b0,1'b1,4'd0,4'd0,4'd0,8'd255,3'd1},  // R7 nmi no rtc
    {1'b1,1'b0,1'b1,1'b1,4'd9,4'd9,4'd1,8'd240,3'd1},  // R5 all three
    {1'b1,1'b0,1'b1,1'b0,4'd9,4'd9,4'd1,8'd245,3'd2},  // R5 irl over gpio
    {1'b1,1'b1,1'b1,1'b0,4'd6,4'd0,4'd1,8'd250,3'd2},  // R8 block ignored
    {1'b0,1'b0,1'b1,1'b0,4'd6,4'd0,4'd1,8'd0,  3'd2},  // R9 light sleep
    {1'b0,1'b1,1'b1,1'b0,4'd6,4'd6,4'd1,8'd0,  3'd0},  // R8 light blocked
    {1'b0,1'b1,1'b1,1'b1,4'd0,4'd0,4'd1,8'd0,  3'd1},  // R8 light nmi
    {1'b1,1'b0,1'b1,1'b0,4'd0,4'd3,4'd3,8'd250,3'd0},  // R6 gpio equal
    {1'b1,1'b0,1'b1,1'b0,4'd0,4'd15,4'd0,8'd0, 3'd3}   // R3 full count
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_wake();
    nmi = 0; irl_lvl = 0; gpio_lvl = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_wake();
    rst_n = 0;
    #1;
    chk(core_clk_en && status1 && status0 && !wake_pulse, "R1 reset outputs",
        {core_clk_en, status1, status0, wake_pulse}, 4'b1110);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] prev_div;
    #1;
    chk(core_clk_en && status1 && status0, "R1 in reset", {core_clk_en, status1, status0}, 3'b111);
    chk(!wake_pulse && wake_code == 0 && div_sel == 0, "R1 reset regs", {wake_pulse, wake_code, div_sel}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(core_clk_en && !status1 && !status0, "R1 after release", {core_clk_en, status1, status0}, 3'b100);

    // R10: wake inputs in the running state
    nmi = 1; rtc_run = 1; irl_lvl = 4'd15; gpio_lvl = 4'd15;
    begin
      int seen = 0;
      repeat (12) begin
        @(posedge clk); #1;
        if (wake_pulse) seen++;
      end
      chk(seen == 0 && core_clk_en, "R10 run ignores wake", seen, 0);
    end
    @(negedge clk); clear_wake(); repeat (3) @(negedge clk);

    prev_div = div_sel;
    for (int i = 0; i < 14; i++) begin
      logic s, b, r, n; logic [3:0] il, gl, im; logic [7:0] stv; logic [2:0] ec;
      int lim, cnt_e, exp_n, early_on;
      {s, b, r, n, il, gl, im, stv, ec} = VEC[i];
      @(negedge clk);
      stby_en = s; int_block = b; rtc_run = r; imask = im;
      cfg_wdt_start = stv; cfg_div_sel = 2'(i);
      sleep_req = 1;
      @(negedge clk);
      sleep_req = 0;
      if (s) prev_div = 2'(i);
      chk(core_clk_en == !s && status0 == s && !status1, s ? "R2 standby entry" : "R9 light entry",
          {core_clk_en, status1, status0}, {!s, 1'b0, s});
      chk(div_sel == prev_div, "R11 div capture", div_sel, prev_div);
      nmi = n; irl_lvl = il; gpio_lvl = gl;
      exp_n = s ? 4 + 255 - int'(stv) : 3;
      lim = (ec == 0) ? 20 : exp_n + 5;
      cnt_e = 0; early_on = 0;
      while (cnt_e < lim) begin
        @(posedge clk); #1;
        cnt_e++;
        if (wake_pulse) break;
        if (core_clk_en == s) early_on++;
      end
      if (ec == 0) begin
        chk(!wake_pulse && cnt_e == lim, "R6 R7 R8 no wake", wake_pulse, 0);
        chk(core_clk_en == !s, "R8 clock held", core_clk_en, !s);
        do_reset();
      end else begin
        chk(wake_pulse && cnt_e == exp_n, s ? "R3 settle length" : "R9 light wake delay", cnt_e, exp_n);
        chk(wake_code == ec, "R5 wake code", wake_code, ec);
        chk(core_clk_en && !status0 && !status1, "R4 exit state", {core_clk_en, status1, status0}, 3'b100);
        chk(early_on == 0, "R3 clock held in settle", early_on, 0);
        @(posedge clk); #1;
        chk(!wake_pulse, "R4 single pulse", wake_pulse, 0);
        @(negedge clk); clear_wake(); repeat (3) @(negedge clk);
      end
    end

    // R11: divider select outside standby entry
    @(negedge clk);
    prev_div = div_sel;
    cfg_div_sel = ~prev_div;
    repeat (3) @(negedge clk);
    chk(div_sel == prev_div, "R11 run change hidden", div_sel, prev_div);
    stby_en = 0; sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    @(negedge clk);
    chk(div_sel == prev_div, "R11 light sleep hidden", div_sel, prev_div);
    nmi = 1;
    repeat (4) @(negedge clk);
    clear_wake(); repeat (3) @(negedge clk);

    // R1: reset during settling count
    stby_en = 1; cfg_wdt_start = 8'd0; sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    nmi = 1;
    repeat (10) @(negedge clk);
    chk(!core_clk_en && status0, "R3 settling in progress", core_clk_en, 0);
    do_reset();
    begin
      int seen = 0, off = 0;
      repeat (300) begin
        @(posedge clk); #1;
        if (wake_pulse) seen++;
        if (!core_clk_en) off++;
      end
      chk(seen == 0 && off == 0, "R1 reset ends standby", seen + off, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule